// File: doc/BRIEF.md
# Task Descriptor Loader with Nonce Partitioning

This block sits behind a serial byte receiver on a hashing device. The host sends framed writes. Each frame starts with a four-byte header: a device identifier, an address byte whose top bit marks a read, and two length bytes. The data bytes follow. A write to the task address carries a 48-byte work descriptor. At the end of the frame the descriptor is unpacked into a 16-bit tag, a 256-bit midstate and 96 bits of trailing header data, and it is placed in a task queue.

Two 32-bit registers, a start and a stride, divide the nonce space across the hashing cores. Core k is always offered the starting nonce start + k × stride. A core that is idle takes the oldest queued task and receives a one-cycle start pulse together with the fields of that task. When the core signals that it is done, it can take another task. The hashing engines themselves lie outside this block.

Top module: `task_loader`

## Requirements
- R1: After reset the queue level is 0, the overflow flag is 0, no core start pulse is asserted, the start and stride registers are zero so every core nonce is 0, and every core is idle.
- R2: A frame counts only when its first byte equals the CHIP_ID parameter and bit 7 of its second byte is 0. Bits 6:0 of that second byte select the address. Frames for another identifier, and reads, change no state. Header bytes three and four, the length, are ignored.
- R3: A write to address 0x30 enqueues one task when cs_act falls, but only if at least 48 data bytes were received. A shorter write is discarded. Data bytes after the 48th are ignored.
- R4: The task tag is data byte 0 (high half) followed by data byte 1 (low half). Data bytes 2 and 3 are ignored. Data byte 4+i appears at midstate bits [8i+7:8i] for i from 0 to 31, and data byte 36+j appears at trailing-data bits [8j+7:8j] for j from 0 to 11.
- R5: Address 0x70 loads the nonce start register and address 0x71 loads the stride register. Each takes its first four data bytes, least significant byte first, when the frame ends. A frame with fewer than four data bytes leaves the register unchanged.
- R6: core_nonce for core k equals start + k × stride modulo 2^32.
- R7: Queued tasks are dispatched oldest first, at most one per cycle, to the lowest-numbered idle core. A task whose frame ends in cycle c raises q_level after the edge ending cycle c+1, and the core start pulse appears after the following edge.
- R8: A one-cycle core_done pulse on a busy core makes that core idle, so it can take a task from the next edge.
- R9: The queue holds QDEPTH tasks. A task that completes while the queue is full, with no dispatch in the same cycle, is dropped and sets ovf_flag. Only reset clears ovf_flag.
- R10: When the queue is full and a dispatch happens in the same cycle as an enqueue, the new task is accepted. The level stays at QDEPTH and ovf_flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_act | input | 1 | High while a frame is in progress |
| rx_vld | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| core_done | input | NCORE | Per-core completion pulse |
| core_go | output | NCORE | Per-core one-cycle task start pulse |
| core_tag | output | NCORE*16 | Tag of each core's current task |
| core_mid | output | NCORE*256 | Midstate of each core's current task |
| core_tail | output | NCORE*96 | Trailing header data of each core's current task |
| core_nonce | output | NCORE*32 | Starting nonce of each core |
| q_level | output | $clog2(QDEPTH+1) | Number of queued tasks |
| ovf_flag | output | 1 | Sticky queue overflow flag |

## Verification
An enqueue and a dispatch can happen in the same cycle. The case that matters is a task frame that ends while all sixteen slots are full. The bench fills the queue while every core is busy. It then drops cs_act on a valid 48-byte task in the same cycle that it pulses core_done for core 0, so the new entry arrives exactly when the freed core pops the head. The result is correct if the level stays at sixteen, the overflow flag stays clear, core 0 receives the oldest task, and the late task comes out last when the queue is drained.

// File: rtl/task_loader_pkg.sv
package task_loader_pkg;

    localparam int HDR_BYTES  = 4;
    localparam int TASK_BYTES = 48;
    localparam int WORD_BYTES = 4;
    localparam int TAG_W      = 16;
    localparam int MID_W      = 256;
    localparam int TAIL_W     = 96;
    localparam int NONCE_W    = 32;
    localparam int MID_OFS    = 4;
    localparam int TAIL_OFS   = 36;
    localparam int STAGE_W    = TASK_BYTES * 8;

    localparam logic [6:0] ADDR_TASK   = 7'h30;
    localparam logic [6:0] ADDR_NSTART = 7'h70;
    localparam logic [6:0] ADDR_NSTEP  = 7'h71;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [MID_W-1:0]  mid;
        logic [TAIL_W-1:0] tail;
    } task_t;

    function automatic task_t unpack_task(input logic [STAGE_W-1:0] raw);
        task_t t;
        t.tag  = {raw[7:0], raw[15:8]};
        t.mid  = raw[MID_OFS*8 +: MID_W];
        t.tail = raw[TAIL_OFS*8 +: TAIL_W];
        return t;
    endfunction

endpackage

// File: rtl/tdl_frame_rx.sv
module tdl_frame_rx
    import task_loader_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h03
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_act,
    input  logic                 rx_vld,
    input  logic [7:0]           rx_byte,
    output task_t                tk_data,
    output logic                 tk_commit,
    output logic                 st_commit,
    output logic                 step_commit,
    output logic [NONCE_W-1:0]   word_data
);
    localparam logic [5:0] CNT_MAX   = 6'h3f;
    localparam logic [5:0] TASK_END  = 6'(HDR_BYTES + TASK_BYTES);
    localparam logic [5:0] WORD_END  = 6'(HDR_BYTES + WORD_BYTES);
    localparam logic [5:0] HDR_CNT   = 6'(HDR_BYTES);

    logic [5:0]         bcnt_q;
    logic               in_frm_q;
    logic               chip_ok_q;
    logic               rd_q;
    logic [6:0]         addr_q;
    logic [STAGE_W-1:0] stage_q;
    logic               frm_end;
    logic               wr_ok;
    logic               acc;
    logic [5:0]         pidx;

    assign acc     = cs_act & rx_vld;
    assign frm_end = in_frm_q & ~cs_act;
    assign wr_ok   = chip_ok_q & ~rd_q;
    assign pidx    = bcnt_q - HDR_CNT;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q      <= '0;
            in_frm_q    <= 1'b0;
            chip_ok_q   <= 1'b0;
            rd_q        <= 1'b1;
            addr_q      <= '0;
            tk_commit   <= 1'b0;
            st_commit   <= 1'b0;
            step_commit <= 1'b0;
        end else begin
            in_frm_q    <= cs_act;
            tk_commit   <= frm_end & wr_ok & (addr_q == ADDR_TASK)   & (bcnt_q >= TASK_END);
            st_commit   <= frm_end & wr_ok & (addr_q == ADDR_NSTART) & (bcnt_q >= WORD_END);
            step_commit <= frm_end & wr_ok & (addr_q == ADDR_NSTEP)  & (bcnt_q >= WORD_END);
            if (!cs_act) begin
                bcnt_q    <= '0;
                chip_ok_q <= 1'b0;
                rd_q      <= 1'b1;
                addr_q    <= '0;
            end else if (rx_vld) begin
                if (bcnt_q == 6'd0) chip_ok_q <= (rx_byte == CHIP_ID);
                if (bcnt_q == 6'd1) {rd_q, addr_q} <= rx_byte;
                if (bcnt_q != CNT_MAX) bcnt_q <= bcnt_q + 6'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (acc && bcnt_q >= HDR_CNT && bcnt_q < TASK_END)
            stage_q[8*pidx +: 8] <= rx_byte;
    end

    always_comb begin
        tk_data   = unpack_task(stage_q);
        word_data = stage_q[NONCE_W-1:0];
    end

    // R3
    commit_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        tk_commit |-> ($past(in_frm_q) && !$past(cs_act)));

    // R5
    commit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tk_commit, st_commit, step_commit}));

endmodule

// File: rtl/tdl_task_fifo.sv
module tdl_task_fifo
    import task_loader_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  task_t         push_data,
    input  logic          pop,
    output task_t         head,
    output logic [CW-1:0] level,
    output logic          ovf
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    task_t         mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] lvl_q;
    logic          ovf_q;
    logic          pop_ok, push_ok;

    assign pop_ok  = pop & (lvl_q != '0);
    assign push_ok = push & ((lvl_q != FULL_LVL) | pop_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (push_ok) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + AW'(1);
            if (pop_ok)  rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   lvl_q <= lvl_q + CW'(1);
                2'b01:   lvl_q <= lvl_q - CW'(1);
                default: lvl_q <= lvl_q;
            endcase
            if (push && !push_ok) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_q] <= push_data;
    end

    assign head  = mem_q[rd_q];
    assign level = lvl_q;
    assign ovf   = ovf_q;

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= FULL_LVL);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

endmodule

// File: rtl/tdl_nonce_split.sv
module tdl_nonce_split
    import task_loader_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     st_wr,
    input  logic                     step_wr,
    input  logic [NONCE_W-1:0]       wdata,
    output logic [NCORE*NONCE_W-1:0] core_nonce
);
    logic [NONCE_W-1:0] start_q, step_q;
    logic [NONCE_W-1:0] chain [NCORE];

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            step_q  <= '0;
        end else begin
            if (st_wr)   start_q <= wdata;
            if (step_wr) step_q  <= wdata;
        end
    end

    assign chain[0] = start_q;

    for (genvar k = 1; k < NCORE; k++) begin : g_chain
        assign chain[k] = chain[k-1] + step_q;
    end

    for (genvar k = 0; k < NCORE; k++) begin : g_out
        assign core_nonce[k*NONCE_W +: NONCE_W] = chain[k];
    end

endmodule

// File: rtl/tdl_dispatch.sv
module tdl_dispatch
    import task_loader_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    have_task,
    input  task_t                   head,
    input  logic [NCORE-1:0]        core_done,
    output logic                    pop_req,
    output logic [NCORE-1:0]        core_go,
    output logic [NCORE*TAG_W-1:0]  core_tag,
    output logic [NCORE*MID_W-1:0]  core_mid,
    output logic [NCORE*TAIL_W-1:0] core_tail
);
    logic [NCORE-1:0] busy_q;
    logic [NCORE-1:0] sel;
    logic [NCORE-1:0] grant;
    logic             found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int k = 0; k < NCORE; k++) begin
            if (!busy_q[k] && !found) begin
                sel[k] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign pop_req = have_task & found;
    assign grant   = pop_req ? sel : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= '0;
            core_go <= '0;
        end else begin
            busy_q  <= (busy_q & ~core_done) | grant;
            core_go <= grant;
        end
    end

    for (genvar k = 0; k < NCORE; k++) begin : g_slot
        task_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)           slot_q <= '0;
            else if (grant[k]) slot_q <= head;
        end
        assign core_tag[k*TAG_W +: TAG_W]    = slot_q.tag;
        assign core_mid[k*MID_W +: MID_W]    = slot_q.mid;
        assign core_tail[k*TAIL_W +: TAIL_W] = slot_q.tail;
    end

    // R7
    go_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_go));

endmodule

// File: rtl/task_loader.sv
module task_loader
    import task_loader_pkg::*;
#(
    parameter int         NCORE   = 4,
    parameter int         QDEPTH  = 16,
    parameter logic [7:0] CHIP_ID = 8'h03,
    localparam int        LVL_W   = $clog2(QDEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_act,
    input  logic                        rx_vld,
    input  logic [7:0]                  rx_byte,
    input  logic [NCORE-1:0]            core_done,
    output logic [NCORE-1:0]            core_go,
    output logic [NCORE*TAG_W-1:0]      core_tag,
    output logic [NCORE*MID_W-1:0]      core_mid,
    output logic [NCORE*TAIL_W-1:0]     core_tail,
    output logic [NCORE*NONCE_W-1:0]    core_nonce,
    output logic [LVL_W-1:0]            q_level,
    output logic                        ovf_flag
);
    task_t              rx_task, q_head;
    logic               tk_commit, st_commit, step_commit;
    logic [NONCE_W-1:0] word_data;
    logic               pop_req;

    tdl_frame_rx #(.CHIP_ID(CHIP_ID)) u_rx (
        .clk(clk), .rst(rst), .cs_act(cs_act), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .tk_data(rx_task), .tk_commit(tk_commit), .st_commit(st_commit),
        .step_commit(step_commit), .word_data(word_data)
    );

    tdl_task_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(tk_commit), .push_data(rx_task),
        .pop(pop_req), .head(q_head), .level(q_level), .ovf(ovf_flag)
    );

    tdl_nonce_split #(.NCORE(NCORE)) u_nonce (
        .clk(clk), .rst(rst), .st_wr(st_commit), .step_wr(step_commit),
        .wdata(word_data), .core_nonce(core_nonce)
    );

    tdl_dispatch #(.NCORE(NCORE)) u_disp (
        .clk(clk), .rst(rst), .have_task(q_level != '0), .head(q_head),
        .core_done(core_done), .pop_req(pop_req), .core_go(core_go),
        .core_tag(core_tag), .core_mid(core_mid), .core_tail(core_tail)
    );

    // R7
    go_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (|core_go) |-> ($past(q_level) != '0));

endmodule

// File: tb/task_loader_test.sv
module task_loader_test;
    import task_loader_pkg::*;

    localparam int NC  = 4;
    localparam int QD  = 16;
    localparam logic [7:0] CID = 8'h03;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   cs_act = 1'b0;
    logic                   rx_vld = 1'b0;
    logic [7:0]             rx_byte = '0;
    logic [NC-1:0]          core_done = '0;
    logic [NC-1:0]          core_go;
    logic [NC*TAG_W-1:0]    core_tag;
    logic [NC*MID_W-1:0]    core_mid;
    logic [NC*TAIL_W-1:0]   core_tail;
    logic [NC*NONCE_W-1:0]  core_nonce;
    logic [$clog2(QD+1)-1:0] q_level;
    logic                   ovf_flag;

    task_loader #(.NCORE(NC), .QDEPTH(QD), .CHIP_ID(CID)) uut (
        .clk(clk), .rst(rst), .cs_act(cs_act), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .core_done(core_done), .core_go(core_go), .core_tag(core_tag),
        .core_mid(core_mid), .core_tail(core_tail), .core_nonce(core_nonce),
        .q_level(q_level), .ovf_flag(ovf_flag)
    );

    always #5 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0]  pl [64];
    logic [15:0] dtag [64];
    int          dcore [64];
    int          dn = 0;
    bit          finished = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < NC; k++) begin
                if (core_go[k] && dn < 64) begin
                    dtag[dn]  = core_tag[k*TAG_W +: TAG_W];
                    dcore[dn] = k;
                    dn++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < 64; i++) pl[i] = seed + 8'(3 * i);
    endtask

    function automatic logic [15:0] exp_tag(input logic [7:0] seed);
        return {seed, seed + 8'd3};
    endfunction

    task automatic send_frame(input logic [7:0] chip, input logic [7:0] addr,
                              input int n, input logic [NC-1:0] dmask);
        logic [7:0] hdr [4];
        hdr[0] = chip; hdr[1] = addr; hdr[2] = 8'(n); hdr[3] = 8'h00;
        @(negedge clk);
        cs_act = 1'b1;
        for (int i = 0; i < 4 + n; i++) begin
            rx_vld  = 1'b1;
            rx_byte = (i < 4) ? hdr[i] : pl[i-4];
            @(negedge clk);
        end
        rx_vld    = 1'b0;
        cs_act    = 1'b0;
        core_done = dmask;
        @(negedge clk);
        core_done = '0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_done(input logic [NC-1:0] m);
        @(negedge clk);
        core_done = m;
        @(negedge clk);
        core_done = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_core_fields(input int k, input logic [7:0] seed, input string req);
        logic [MID_W-1:0]  em;
        logic [TAIL_W-1:0] et;
        for (int i = 0; i < 32; i++) em[8*i +: 8] = seed + 8'(3 * (4 + i));
        for (int j = 0; j < 12; j++) et[8*j +: 8] = seed + 8'(3 * (36 + j));
        chk(core_tag[k*TAG_W +: TAG_W] == exp_tag(seed), req,
            32'(core_tag[k*TAG_W +: TAG_W]), 32'(exp_tag(seed)));
        chk(core_mid[k*MID_W +: MID_W] == em, req,
            core_mid[k*MID_W +: 32], em[31:0]);
        chk(core_tail[k*TAIL_W +: TAIL_W] == et, req,
            core_tail[k*TAIL_W +: 32], et[31:0]);
    endtask

    task automatic t_reset();
        chk(q_level == 0, "R1 level", 32'(q_level), 0);
        chk(ovf_flag == 0, "R1 ovf", 32'(ovf_flag), 0);
        chk(core_go == 0, "R1 go", 32'(core_go), 0);
        for (int k = 0; k < NC; k++)
            chk(core_nonce[k*32 +: 32] == 0, "R1 nonce", core_nonce[k*32 +: 32], 0);
    endtask

    task automatic check_nonces(input logic [31:0] s, input logic [31:0] st, input string req);
        for (int k = 0; k < NC; k++)
            chk(core_nonce[k*32 +: 32] == 32'(s + 32'(k) * st), req,
                core_nonce[k*32 +: 32], 32'(s + 32'(k) * st));
    endtask

    task automatic t_nonce();
        pl[0] = 8'h00; pl[1] = 8'h00; pl[2] = 8'h00; pl[3] = 8'hF0;
        send_frame(CID, 8'h70, 4, '0);
        pl[3] = 8'h60;
        send_frame(CID, 8'h71, 4, '0);
        settle();
        // R5 R6: wrap modulo 2^32 on core 3
        check_nonces(32'hF000_0000, 32'h6000_0000, "R6 partition");
        pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33; pl[3] = 8'h44;
        send_frame(CID, 8'h71, 3, '0);
        settle();
        check_nonces(32'hF000_0000, 32'h6000_0000, "R5 short word write");
        send_frame(CID, 8'hF0, 4, '0);
        send_frame(8'h05, 8'h70, 4, '0);
        settle();
        check_nonces(32'hF000_0000, 32'h6000_0000, "R2 read or other chip");
        pl[0] = 8'h10; pl[1] = 8'h00; pl[2] = 8'h00; pl[3] = 8'h00;
        send_frame(CID, 8'h70, 6, '0);
        settle();
        check_nonces(32'h0000_0010, 32'h6000_0000, "R5 start lsb first");
    endtask

    task automatic t_basic();
        int d0;
        fill(8'd1);
        send_frame(CID, 8'h30, 48, '0);
        @(negedge clk);
        chk(q_level == 1, "R7 level timing", 32'(q_level), 1);
        chk(core_go == 0, "R7 go not yet", 32'(core_go), 0);
        @(negedge clk);
        chk(core_go == 4'b0001, "R7 go timing", 32'(core_go), 1);
        chk(q_level == 0, "R7 popped", 32'(q_level), 0);
        check_core_fields(0, 8'd1, "R4 fields");
        fill(8'd2);
        send_frame(CID, 8'h30, 48, '0);
        settle();
        chk(dn == 2 && dcore[1] == 1, "R7 lowest idle", 32'(dcore[1]), 1);
        check_core_fields(1, 8'd2, "R4 fields core1");
        d0 = dn;
        fill(8'd3);
        send_frame(CID, 8'h30, 47, '0);
        settle();
        chk(dn == d0 && q_level == 0, "R3 short task dropped", 32'(dn), 32'(d0));
        fill(8'd4);
        send_frame(8'h05, 8'h30, 48, '0);
        send_frame(CID, 8'hB0, 48, '0);
        settle();
        chk(dn == d0 && q_level == 0, "R2 foreign or read task", 32'(dn), 32'(d0));
        fill(8'd5);
        send_frame(CID, 8'h30, 50, '0);
        settle();
        chk(dn == d0 + 1 && dcore[d0] == 2, "R3 long task core2", 32'(dcore[d0]), 2);
        check_core_fields(2, 8'd5, "R3 extra bytes ignored");
    endtask

    task automatic t_done();
        pulse_done(4'b0010);
        fill(8'd6);
        send_frame(CID, 8'h30, 48, '0);
        settle();
        chk(dcore[dn-1] == 1 && dtag[dn-1] == exp_tag(8'd6), "R8 freed core reused",
            32'(dcore[dn-1]), 1);
        fill(8'd7);
        send_frame(CID, 8'h30, 48, '0);
        settle();
        chk(dcore[dn-1] == 3, "R7 last idle core", 32'(dcore[dn-1]), 3);
    endtask

    task automatic t_full();
        int d0;
        d0 = dn;
        for (int s = 10; s < 26; s++) begin
            fill(8'(s));
            send_frame(CID, 8'h30, 48, '0);
        end
        settle();
        chk(q_level == QD && dn == d0, "R9 queue fills", 32'(q_level), QD);
        chk(ovf_flag == 0, "R9 no ovf at depth", 32'(ovf_flag), 0);
        // R10: enqueue and dispatch in the same cycle
        fill(8'd40);
        send_frame(CID, 8'h30, 48, 4'b0001);
        settle();
        chk(q_level == QD, "R10 level held", 32'(q_level), QD);
        chk(ovf_flag == 0, "R10 no ovf", 32'(ovf_flag), 0);
        chk(dcore[dn-1] == 0 && dtag[dn-1] == exp_tag(8'd10), "R10 head to core0",
            32'(dtag[dn-1]), 32'(exp_tag(8'd10)));
        fill(8'd50);
        send_frame(CID, 8'h30, 48, '0);
        settle();
        chk(ovf_flag == 1 && q_level == QD, "R9 overflow drop", 32'(ovf_flag), 1);
    endtask

    task automatic t_drain();
        logic [15:0] e;
        for (int i = 0; i < QD; i++) begin
            pulse_done(4'b0001);
            e = (i < QD - 1) ? exp_tag(8'(11 + i)) : exp_tag(8'd40);
            chk(dtag[dn-1] == e, "R7 fifo order", 32'(dtag[dn-1]), 32'(e));
        end
        chk(q_level == 0, "R9 drained", 32'(q_level), 0);
        chk(ovf_flag == 1, "R9 ovf sticky", 32'(ovf_flag), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_nonce();
        t_basic();
        t_done();
        t_full();
        t_drain();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule